// File: doc/BRIEF.md
# Eight-Bit Flag ALU

This block is the arithmetic and logic stage of a small eight-bit controller core. Each cycle it can take a destination operand and a source operand. The source is either a second register value or an immediate constant. It also takes an operation code and an enable strobe. It computes a result together with next-state zero and carry flags, using the carry flag it holds itself as the incoming carry.

All outputs are registered. On a rising edge where the enable is high, the result register, the one-cycle write-enable pulse and the two flag registers take their new values according to the operation. The surrounding core writes `result` back to its register file whenever `resultWe` is high.

The block covers these operations:
- Bitwise logic, which always clears the carry flag.
- Add and subtract, each with or without the incoming carry.
- A test operation that reports the odd parity of a bitwise AND in the carry flag.
- A compare operation.
- A plain load, which changes no flag.

Test and compare change only the flags.

Top module: `flag_alu`

## Requirements
- R1: A synchronous active-high reset clears both flags, the result register and the write-enable pulse.
- R2: On an edge where `en` is low, `resultWe` goes low and the result and both flags keep their values.
- R3: Operation code 0 (load) writes the selected source operand to `result`, raises `resultWe` for one cycle and leaves both flags unchanged.
- R4: Codes 1, 2 and 3 (AND, OR, XOR of destination and source) write the result back, clear the carry flag, and set zero exactly when the result is 0.
- R5: Code 4 (add) writes the low eight bits of destination plus source, sets carry when the true sum exceeds 255, and sets zero when the written value is 0.
- R6: Code 5 (add with carry) also adds the carry flag held before the edge, with the same carry and zero rules as R5.
- R7: Code 6 (subtract) writes destination minus source modulo 256, sets carry when the true difference is below 0, and sets zero when the written value is 0.
- R8: Code 7 (subtract with carry) also subtracts the held carry flag, with the same borrow and zero rules as R7.
- R9: Code 8 (test) writes nothing and keeps `result`. It sets zero when destination AND source is 0 and sets carry to the XOR of all bits of that AND.
- R10: Code 9 (compare) writes nothing and keeps `result`. It sets the flags as code 6 would, and ignores the held carry.
- R11: For codes 5 and 7, zero reflects only the current eight-bit result and does not depend on the previous zero flag.
- R12: When `selImm` is 1 the source operand is `immVal`; when it is 0 the source operand is `opB`.
- R13: Codes 10 to 15 write nothing and leave the result and both flags unchanged.
- R14: Every update caused by an enabled edge is visible on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execute strobe for the current operation |
| op | input | 4 | Operation code |
| opA | input | W | Destination register value |
| opB | input | W | Source register value |
| immVal | input | W | Immediate constant |
| selImm | input | 1 | Selects the immediate as the source operand |
| result | output | W | Registered result |
| resultWe | output | 1 | One-cycle write-back strobe for the destination |
| zeroFlag | output | 1 | Zero flag register |
| carryFlag | output | 1 | Carry flag register |

## Verification
The bench builds the block with its default width of eight bits. At this width, every carry and borrow boundary can be reached with literal operands: 0xFF plus 1, 0x80 plus 0x80, and 0 minus 1 with a held borrow. The zero flag can also be driven through results that reach exactly zero only because of the incoming carry.

Parity cases use AND values with an odd and an even number of set bits. Carry is set before the operations that must ignore it or clear it, so that a stale flag shows up on the outputs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADDC = 4'd5,
    OP_SUB  = 4'd6,
    OP_SUBC = 4'd7,
    OP_TEST = 4'd8,
    OP_CMP  = 4'd9
  } opCode_e;

  typedef enum logic [1:0] {
    LG_PASS = 2'd0,
    LG_AND  = 2'd1,
    LG_OR   = 2'd2,
    LG_XOR  = 2'd3
  } logicSel_e;

  typedef enum logic [1:0] {
    CS_ZERO   = 2'd0,
    CS_ARITH  = 2'd1,
    CS_PARITY = 2'd2
  } carrySel_e;

  typedef struct packed {
    logic      wrRes;
    logic      updFlags;
    logic      arith;
    logic      isSub;
    logic      useCarry;
    logicSel_e logicSel;
    carrySel_e carrySel;
  } aluStrobes_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0]  op,
  output aluStrobes_t stb
);

  always_comb begin
    stb = '{wrRes: 1'b0, updFlags: 1'b0, arith: 1'b0, isSub: 1'b0,
            useCarry: 1'b0, logicSel: LG_PASS, carrySel: CS_ZERO};
    case (op)
      OP_LOAD: begin
        stb.wrRes = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        stb.wrRes    = 1'b1;
        stb.updFlags = 1'b1;
        stb.carrySel = CS_ZERO;
        stb.logicSel = (op == OP_AND) ? LG_AND : ((op == OP_OR) ? LG_OR : LG_XOR);
      end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        stb.wrRes    = 1'b1;
        stb.updFlags = 1'b1;
        stb.arith    = 1'b1;
        stb.carrySel = CS_ARITH;
        stb.isSub    = (op == OP_SUB) || (op == OP_SUBC);
        stb.useCarry = (op == OP_ADDC) || (op == OP_SUBC);
      end
      OP_TEST: begin
        stb.updFlags = 1'b1;
        stb.logicSel = LG_AND;
        stb.carrySel = CS_PARITY;
      end
      OP_CMP: begin
        stb.updFlags = 1'b1;
        stb.arith    = 1'b1;
        stb.isSub    = 1'b1;
        stb.carrySel = CS_ARITH;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  aluStrobes_t     stb,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic [W-1:0]    immVal,
  input  logic            selImm,
  output logic [W-1:0]    result,
  output logic            resultWe,
  output logic            zeroFlag,
  output logic            carryFlag
);

  localparam int EXT_W = W + 1;

  logic [W-1:0]     srcVal;
  logic [EXT_W-1:0] arithOut;
  logic [EXT_W-1:0] cinExt;
  logic [W-1:0]     logicOut;
  logic [W-1:0]     resNext;
  logic             zeroNext;
  logic             carryNext;

  assign srcVal = selImm ? immVal : opB;
  assign cinExt = {{W{1'b0}}, (stb.useCarry & carryFlag)};

  always_comb begin
    if (stb.isSub) arithOut = {1'b0, opA} - {1'b0, srcVal} - cinExt;
    else           arithOut = {1'b0, opA} + {1'b0, srcVal} + cinExt;
  end

  always_comb begin
    case (stb.logicSel)
      LG_AND:  logicOut = opA & srcVal;
      LG_OR:   logicOut = opA | srcVal;
      LG_XOR:  logicOut = opA ^ srcVal;
      default: logicOut = srcVal;
    endcase
  end

  assign resNext  = stb.arith ? arithOut[W-1:0] : logicOut;
  assign zeroNext = (resNext == '0);

  always_comb begin
    case (stb.carrySel)
      CS_ARITH:  carryNext = arithOut[W];
      CS_PARITY: carryNext = ^logicOut;
      default:   carryNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      resultWe  <= 1'b0;
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else begin
      resultWe <= en & stb.wrRes;
      if (en && stb.wrRes) result <= resNext;
      if (en && stb.updFlags) begin
        zeroFlag  <= zeroNext;
        carryFlag <= carryNext;
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] immVal,
  input  logic         selImm,
  output logic [W-1:0] result,
  output logic         resultWe,
  output logic         zeroFlag,
  output logic         carryFlag
);

  aluStrobes_t stb;

  flag_alu_ctrl u_ctrl (
    .op  (op),
    .stb (stb)
  );

  flag_alu_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .stb       (stb),
    .opA       (opA),
    .opB       (opB),
    .immVal    (immVal),
    .selImm    (selImm),
    .result    (result),
    .resultWe  (resultWe),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [3:0]   op,
  input logic [W-1:0] result,
  input logic         resultWe,
  input logic         zeroFlag,
  input logic         carryFlag
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!zeroFlag && !carryFlag && !resultWe && result == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!resultWe && $stable(result) && $stable(zeroFlag) && $stable(carryFlag)));

  // R3
  load_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_LOAD) |=> (resultWe && $stable(zeroFlag) && $stable(carryFlag)));

  // R4
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (resultWe && !carryFlag));

  // R9
  flag_only_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_TEST || op == OP_CMP)) |=> (!resultWe && $stable(result)));

  // R11
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op >= OP_AND && op <= OP_SUBC) |=> (zeroFlag == (result == '0)));

  // R13
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op > OP_CMP) |=> (!resultWe && $stable(result) && $stable(zeroFlag) && $stable(carryFlag)));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .op        (op),
  .result    (result),
  .resultWe  (resultWe),
  .zeroFlag  (zeroFlag),
  .carryFlag (carryFlag)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  import flag_alu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [3:0]   op = 4'd0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] immVal = '0;
  logic         selImm = 1'b0;
  logic [W-1:0] result;
  logic         resultWe;
  logic         zeroFlag;
  logic         carryFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic         we;
    logic [W-1:0] res;
    logic         z;
    logic         c;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];

  logic [W-1:0] mRes = '0;
  logic         mZ = 1'b0;
  logic         mC = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu #(.W(W)) u_flag_alu (
    .clk(clk), .rst(rst), .en(en), .op(op), .opA(opA), .opB(opB),
    .immVal(immVal), .selImm(selImm), .result(result), .resultWe(resultWe),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  task automatic issue(input logic e, input logic [3:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic si, input logic [W-1:0] im,
                       input string tag);
    logic [W-1:0] src;
    logic [W:0]   t;
    logic         we;
    expItem_t     it;
    @(negedge clk);
    en = e; op = o; opA = a; opB = b; selImm = si; immVal = im;
    src = si ? im : b;
    we  = 1'b0;
    if (e) begin
      case (o)
        4'd0: begin we = 1'b1; mRes = src; end
        4'd1, 4'd2, 4'd3: begin
          we = 1'b1;
          mRes = (o == 4'd1) ? (a & src) : ((o == 4'd2) ? (a | src) : (a ^ src));
          mZ = (mRes == '0); mC = 1'b0;
        end
        4'd4, 4'd5: begin
          t = {1'b0, a} + {1'b0, src} + ((o == 4'd5) ? {{W{1'b0}}, mC} : '0);
          we = 1'b1; mRes = t[W-1:0]; mZ = (mRes == '0); mC = (t > 255);
        end
        4'd6, 4'd7: begin
          t = {1'b0, a} - {1'b0, src} - ((o == 4'd7) ? {{W{1'b0}}, mC} : '0);
          we = 1'b1; mRes = t[W-1:0]; mZ = (mRes == '0);
          mC = (int'(a) - int'(src) - ((o == 4'd7) ? int'(mC) : 0)) < 0;
        end
        4'd8: begin mZ = ((a & src) == '0); mC = ^(a & src); end
        4'd9: begin mZ = (a == src); mC = (a < src); end
        default: ;
      endcase
    end
    it.we = we; it.res = mRes; it.z = mZ; it.c = mC; it.tag = tag;
    expQ.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (resultWe !== it.we || result !== it.res || zeroFlag !== it.z || carryFlag !== it.c) begin
        errors++;
        $display("FAIL %s: got we=%b res=%h z=%b c=%b expected we=%b res=%h z=%b c=%b",
                 it.tag, resultWe, result, zeroFlag, carryFlag, it.we, it.res, it.z, it.c);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (resultWe !== 1'b0 || result !== '0 || zeroFlag !== 1'b0 || carryFlag !== 1'b0) begin
      errors++;
      $display("FAIL R1: got we=%b res=%h z=%b c=%b expected all zero",
               resultWe, result, zeroFlag, carryFlag);
    end
    rst = 1'b0;

    issue(1, OP_LOAD, 8'h00, 8'h5A, 0, 8'h00, "R3 R14 load");
    issue(1, OP_ADD,  8'hF0, 8'h20, 0, 8'h00, "R5 add overflow");
    issue(1, OP_LOAD, 8'h00, 8'h00, 0, 8'h00, "R3 load keeps carry");
    issue(1, OP_AND,  8'hFF, 8'h00, 1, 8'h0F, "R4 R12 and immediate");
    issue(1, OP_ADD,  8'h80, 8'h80, 0, 8'h00, "R5 add to zero");
    issue(1, OP_ADDC, 8'h01, 8'h01, 0, 8'h00, "R6 addc carry in");
    issue(1, OP_ADD,  8'hFF, 8'h01, 0, 8'h00, "R5 add wrap");
    issue(1, OP_ADDC, 8'hFF, 8'h00, 0, 8'h00, "R6 R11 addc to zero");
    issue(1, OP_ADDC, 8'h00, 8'h00, 0, 8'h00, "R11 addc nonzero");
    issue(1, OP_SUB,  8'h10, 8'h20, 0, 8'h00, "R7 sub borrow");
    issue(1, OP_SUBC, 8'h00, 8'h00, 0, 8'h00, "R8 subc borrow in");
    issue(1, OP_SUBC, 8'h01, 8'h00, 0, 8'h00, "R8 R11 subc to zero");
    issue(1, OP_SUB,  8'h05, 8'h05, 0, 8'h00, "R7 sub equal");
    issue(1, OP_ADD,  8'hFF, 8'hFF, 0, 8'h00, "R5 set carry");
    issue(1, OP_XOR,  8'hAA, 8'h00, 1, 8'hAA, "R4 R12 xor zero");
    issue(1, OP_OR,   8'h30, 8'h03, 0, 8'hFF, "R4 R12 or register");
    issue(1, OP_TEST, 8'h07, 8'h03, 0, 8'h00, "R9 test even parity");
    issue(1, OP_TEST, 8'h07, 8'h01, 0, 8'h00, "R9 test odd parity");
    issue(1, OP_TEST, 8'hF0, 8'h0F, 0, 8'h00, "R9 test zero");
    issue(1, OP_CMP,  8'h10, 8'h20, 0, 8'h00, "R10 compare less");
    issue(1, OP_CMP,  8'h05, 8'h05, 0, 8'h00, "R10 compare equal ignores carry");
    issue(1, OP_CMP,  8'h40, 8'h10, 1, 8'h50, "R10 R12 compare immediate");
    issue(0, OP_ADD,  8'hFF, 8'hFF, 0, 8'h00, "R2 disabled");
    issue(1, 4'd12,   8'h00, 8'h00, 0, 8'h00, "R13 unused code");
    issue(1, 4'd15,   8'hFF, 8'h01, 0, 8'h00, "R13 unused code high");
    issue(0, OP_LOAD, 8'h00, 8'h00, 0, 8'h00, "R2 idle");

    repeat (3) @(negedge clk);
    en = 1'b0;
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R14: got %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule